// File: doc/BRIEF.md
# Dispatch Group Slot Tracker

This block follows how a superscalar front end packs instructions into fixed-size dispatch groups. Every cycle a scheduler offers one candidate instruction. The candidate is described by its execution-unit class and by five flags: first-only, single, cracked, sets-count-register and branches-via-count-register. The block answers at once, in the same cycle, with one of three verdicts:

- **none**: the candidate may join the current group.
- **stall**: the candidate cannot join this group.
- **no-op**: a filler slot must be inserted first, to avoid a costly structural hazard.

The block holds two pieces of state: the slot count of the open group, and a flag that records that the count register was written inside that group. A separate address-compare unit decides whether a load overlaps an earlier store in the group. Its answer enters here only as the `overlap_i` input. `group_close_o` tells that unit when to clear its store list.

Two strobes move the block forward. `issue_i` commits the candidate that is offered. `advance_i` consumes one empty slot. The two strobes never rise in the same cycle. The candidate and verdict are plain control pins with no valid/ready pair. The scheduler decides what to do with the verdict, so there is no back-pressure at this edge.

Top module: `dgroup_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the slot count at 0 and `ctr_pending_o` low.
- R2: A non-pseudo candidate marked first-only or single gets verdict stall whenever the slot count is not 0. At count 0 it gets no stall for that reason.
- R3: A cracked candidate gets stall when the slot count is above SLOTS-3 (above 2 by default). Issuing a cracked instruction adds two to the count.
- R4: Unit codes are: 0 pseudo, 1 fixed-point, 2 load/store, 3 floating-point, 4 vector ALU, 5 vector permute, 6 condition-register, 7 branch. Codes 1 to 5 get stall when the count equals SLOTS-1, the last slot. Code 7 has no slot limit.
- R5: A condition-register candidate (code 6) gets stall when the count is CR_SLOTS (2) or more.
- R6: Issuing a non-pseudo, non-branch, non-single instruction adds one to the count. Issuing a branch or a single instruction closes the group.
- R7: When a commit brings the count to SLOTS or beyond, the group closes. In that same cycle `group_close_o` is high. After the edge the count is 0 and `ctr_pending_o` is low.
- R8: Issuing an instruction that sets the count register raises `ctr_pending_o`. While that flag is high, a candidate that branches via the count register gets verdict no-op.
- R9: With `overlap_i` high and no stall condition present, a non-pseudo candidate gets verdict no-op.
- R10: Verdict codes are: 2'b00 none, 2'b01 stall, 2'b10 no-op. Stall takes priority over no-op.
- R11: `advance_i` adds one to the count and closes the group when the count reaches SLOTS.
- R12: A pseudo candidate (code 0) always gets verdict none. Issuing it leaves the count and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| unit_i | input | 3 | Unit class of the candidate |
| first_only_i | input | 1 | Candidate must open a group |
| single_i | input | 1 | Candidate fills a whole group |
| cracked_i | input | 1 | Candidate splits into two slots |
| sets_ctr_i | input | 1 | Candidate writes the count register |
| uses_ctr_i | input | 1 | Candidate branches via the count register |
| overlap_i | input | 1 | External load/store overlap verdict |
| issue_i | input | 1 | Commit the candidate |
| advance_i | input | 1 | Consume one empty slot |
| verdict_o | output | 2 | Hazard verdict for the candidate |
| slot_count_o | output | CNT_W (3) | Slots used in the open group |
| ctr_pending_o | output | 1 | Count register written in this group |
| group_close_o | output | 1 | The current commit closes the group |

## Verification
The bench builds the tracker with its defaults: five slots, a condition-register window of two, and a three-bit count. With these values every slot position from 0 to 4 can be reached in a few commits. So each position-dependent rule can be reached at both of its edges:

- the branch-only last slot;
- the cracked threshold at count 2 against count 3;
- the condition-register window.

The bench also drives group closure through all three routes (branch, single, and filling slots one at a time) and a mix of commits and advances. It checks the stall-over-no-op priority, the clearing of the count-register flag at the group boundary, and a mid-group reset.

// File: rtl/dgt_pkg.sv
package dgt_pkg;

  typedef enum logic [2:0] {
    U_PSEUDO = 3'd0,
    U_FIX    = 3'd1,
    U_LDST   = 3'd2,
    U_FLT    = 3'd3,
    U_VALU   = 3'd4,
    U_VPERM  = 3'd5,
    U_CREG   = 3'd6,
    U_BRANCH = 3'd7
  } unit_e;

  typedef enum logic [1:0] {
    V_NONE  = 2'b00,
    V_STALL = 2'b01,
    V_NOOP  = 2'b10
  } verdict_e;

  typedef struct packed {
    unit_e unit;
    logic  first_only;
    logic  single;
    logic  cracked;
    logic  sets_ctr;
    logic  uses_ctr;
  } cand_t;

  function automatic logic is_slot_limited(unit_e u);
    return (u == U_FIX) || (u == U_LDST) || (u == U_FLT) ||
           (u == U_VALU) || (u == U_VPERM);
  endfunction

endpackage

// File: rtl/dgt_legality.sv
module dgt_legality
  import dgt_pkg::*;
#(
  parameter int SLOTS    = 5,
  parameter int CR_SLOTS = 2,
  localparam int CNT_W   = $clog2(SLOTS)
) (
  input  cand_t              cand,
  input  logic [CNT_W-1:0]   count,
  input  logic               ctr_pending,
  input  logic               overlap,
  output verdict_e           verdict
);

  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] CR_LIMIT  = CNT_W'(CR_SLOTS);
  localparam logic [CNT_W-1:0] CRACK_MAX = CNT_W'(SLOTS - 3);

  logic real_op;
  logic stall_pos, stall_crack, stall_unit, stall_cr;
  logic noop_ctr, noop_mem;

  always_comb begin
    real_op     = (cand.unit != U_PSEUDO);
    stall_pos   = (count != '0) && (cand.first_only || cand.single);
    stall_crack = cand.cracked && (count > CRACK_MAX);
    stall_unit  = is_slot_limited(cand.unit) && (count == LAST_SLOT);
    stall_cr    = (cand.unit == U_CREG) && (count >= CR_LIMIT);
    noop_ctr    = ctr_pending && cand.uses_ctr;
    noop_mem    = overlap;

    if (!real_op)
      verdict = V_NONE;
    else if (stall_pos || stall_crack || stall_unit || stall_cr)
      verdict = V_STALL;
    else if (noop_ctr || noop_mem)
      verdict = V_NOOP;
    else
      verdict = V_NONE;
  end

endmodule

// File: rtl/dgt_slot_counter.sv
module dgt_slot_counter
  import dgt_pkg::*;
#(
  parameter int SLOTS  = 5,
  localparam int CNT_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  cand_t            cand,
  input  logic             issue,
  input  logic             advance,
  output logic [CNT_W-1:0] count,
  output logic             ctr_pending,
  output logic             close
);

  localparam logic [CNT_W:0] FULL      = (CNT_W+1)'(SLOTS);
  localparam logic [CNT_W:0] LAST_WIDE = (CNT_W+1)'(SLOTS - 1);

  logic [CNT_W:0]   base;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] count_n;
  logic             pending_n;
  logic             commit;

  always_comb begin
    commit    = 1'b0;
    base      = {1'b0, count};
    sum       = base;
    pending_n = ctr_pending;
    if (issue && cand.unit != U_PSEUDO) begin
      commit    = 1'b1;
      if (cand.unit == U_BRANCH || cand.single)
        base = LAST_WIDE;
      sum       = base + 1'b1 + {{CNT_W{1'b0}}, cand.cracked};
      pending_n = ctr_pending | cand.sets_ctr;
    end else if (advance) begin
      commit = 1'b1;
      sum    = base + 1'b1;
    end
    close = commit && (sum >= FULL);
    if (close) begin
      count_n   = '0;
      pending_n = 1'b0;
    end else begin
      count_n   = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count       <= '0;
      ctr_pending <= 1'b0;
    end else begin
      count       <= count_n;
      ctr_pending <= pending_n;
    end
  end

endmodule

// File: rtl/dgroup_tracker.sv
module dgroup_tracker
  import dgt_pkg::*;
#(
  parameter int SLOTS    = 5,
  parameter int CR_SLOTS = 2,
  localparam int CNT_W   = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       unit_i,
  input  logic             first_only_i,
  input  logic             single_i,
  input  logic             cracked_i,
  input  logic             sets_ctr_i,
  input  logic             uses_ctr_i,
  input  logic             overlap_i,
  input  logic             issue_i,
  input  logic             advance_i,
  output logic [1:0]       verdict_o,
  output logic [CNT_W-1:0] slot_count_o,
  output logic             ctr_pending_o,
  output logic             group_close_o
);

  cand_t    cand;
  verdict_e verdict;

  always_comb begin
    cand.unit       = unit_e'(unit_i);
    cand.first_only = first_only_i;
    cand.single     = single_i;
    cand.cracked    = cracked_i;
    cand.sets_ctr   = sets_ctr_i;
    cand.uses_ctr   = uses_ctr_i;
  end

  dgt_legality #(.SLOTS(SLOTS), .CR_SLOTS(CR_SLOTS)) u_legal (
    .cand        (cand),
    .count       (slot_count_o),
    .ctr_pending (ctr_pending_o),
    .overlap     (overlap_i),
    .verdict     (verdict)
  );

  dgt_slot_counter #(.SLOTS(SLOTS)) u_count (
    .clk         (clk),
    .rst         (rst),
    .cand        (cand),
    .issue       (issue_i),
    .advance     (advance_i),
    .count       (slot_count_o),
    .ctr_pending (ctr_pending_o),
    .close       (group_close_o)
  );

  assign verdict_o = verdict;

endmodule

// File: rtl/dgt_checker.sv
module dgt_checker #(
  parameter int SLOTS  = 5,
  localparam int CNT_W = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       unit_i,
  input logic             first_only_i,
  input logic             single_i,
  input logic             issue_i,
  input logic             advance_i,
  input logic [1:0]       verdict_o,
  input logic [CNT_W-1:0] slot_count_o,
  input logic             ctr_pending_o,
  input logic             group_close_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  AST_RESET_EMPTY: assert property (@(posedge clk)
    $past(rst) |-> (slot_count_o == '0 && !ctr_pending_o)); // R1

  AST_MID_FIRST_STALL: assert property (@(posedge clk) disable iff (rst)
    (unit_i != 3'd0 && slot_count_o != '0 && (first_only_i || single_i))
      |-> verdict_o == 2'b01); // R2

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    slot_count_o <= LAST); // R7

  AST_CLOSE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    group_close_o |=> (slot_count_o == '0 && !ctr_pending_o)); // R7

  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (rst)
    (advance_i && !issue_i && slot_count_o < LAST)
      |=> slot_count_o == $past(slot_count_o) + 1'b1); // R11

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(issue_i && advance_i)); // R11

  AST_PSEUDO_INERT: assert property (@(posedge clk) disable iff (rst)
    (issue_i && unit_i == 3'd0)
      |=> ($stable(slot_count_o) && $stable(ctr_pending_o))); // R12

  AST_PSEUDO_NONE: assert property (@(posedge clk) disable iff (rst)
    (unit_i == 3'd0) |-> verdict_o == 2'b00); // R12

endmodule

bind dgroup_tracker dgt_checker #(.SLOTS(SLOTS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .unit_i        (unit_i),
  .first_only_i  (first_only_i),
  .single_i      (single_i),
  .issue_i       (issue_i),
  .advance_i     (advance_i),
  .verdict_o     (verdict_o),
  .slot_count_o  (slot_count_o),
  .ctr_pending_o (ctr_pending_o),
  .group_close_o (group_close_o)
);

// File: tb/dgroup_tracker_test.sv
module dgroup_tracker_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] unit_i = '0;
  logic       first_only_i = 1'b0, single_i = 1'b0, cracked_i = 1'b0;
  logic       sets_ctr_i = 1'b0, uses_ctr_i = 1'b0, overlap_i = 1'b0;
  logic       issue_i = 1'b0, advance_i = 1'b0;
  logic [1:0] verdict_o;
  logic [2:0] slot_count_o;
  logic       ctr_pending_o, group_close_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dgroup_tracker uut (
    .clk(clk), .rst(rst), .unit_i(unit_i),
    .first_only_i(first_only_i), .single_i(single_i), .cracked_i(cracked_i),
    .sets_ctr_i(sets_ctr_i), .uses_ctr_i(uses_ctr_i), .overlap_i(overlap_i),
    .issue_i(issue_i), .advance_i(advance_i),
    .verdict_o(verdict_o), .slot_count_o(slot_count_o),
    .ctr_pending_o(ctr_pending_o), .group_close_o(group_close_o)
  );

  // {op(0 idle,1 issue,2 advance), unit, first,single,crack,setctr,usectr,overlap,
  //  expected verdict, expected close, expected count after edge}
  localparam int NV = 26;
  localparam logic [16:0] VEC [NV] = '{
    {2'd1, 3'd1, 6'b000000, 2'd0, 1'b0, 3'd1},  // R6 fixed-point issue
    {2'd0, 3'd1, 6'b100000, 2'd1, 1'b0, 3'd1},  // R2 first-only mid group
    {2'd1, 3'd6, 6'b000000, 2'd0, 1'b0, 3'd2},  // R5 CR at slot 1
    {2'd0, 3'd6, 6'b000000, 2'd1, 1'b0, 3'd2},  // R5 CR at slot 2
    {2'd1, 3'd1, 6'b001000, 2'd0, 1'b0, 3'd4},  // R3 cracked at 2
    {2'd0, 3'd2, 6'b000000, 2'd1, 1'b0, 3'd4},  // R4 load/store at last slot
    {2'd1, 3'd7, 6'b000000, 2'd0, 1'b1, 3'd0},  // R4 R7 branch in last slot
    {2'd1, 3'd1, 6'b000100, 2'd0, 1'b0, 3'd1},  // R8 set count register
    {2'd0, 3'd7, 6'b000010, 2'd2, 1'b0, 3'd1},  // R8 branch via ctr
    {2'd0, 3'd1, 6'b100010, 2'd1, 1'b0, 3'd1},  // R10 stall beats no-op
    {2'd2, 3'd0, 6'b000000, 2'd0, 1'b0, 3'd2},  // R11
    {2'd2, 3'd0, 6'b000000, 2'd0, 1'b0, 3'd3},  // R11
    {2'd2, 3'd0, 6'b000000, 2'd0, 1'b0, 3'd4},  // R11
    {2'd2, 3'd0, 6'b000000, 2'd0, 1'b1, 3'd0},  // R11 R7 close by advance
    {2'd0, 3'd7, 6'b000010, 2'd0, 1'b0, 3'd0},  // R7 flag cleared
    {2'd0, 3'd2, 6'b000001, 2'd2, 1'b0, 3'd0},  // R9 overlap no-op
    {2'd1, 3'd1, 6'b010000, 2'd0, 1'b1, 3'd0},  // R6 single closes
    {2'd1, 3'd1, 6'b000000, 2'd0, 1'b0, 3'd1},  // R6
    {2'd1, 3'd1, 6'b001000, 2'd0, 1'b0, 3'd3},  // R3 cracked adds two
    {2'd0, 3'd1, 6'b001000, 2'd1, 1'b0, 3'd3},  // R3 cracked at 3
    {2'd1, 3'd0, 6'b111111, 2'd0, 1'b0, 3'd3},  // R12 pseudo inert
    {2'd0, 3'd7, 6'b000000, 2'd0, 1'b0, 3'd3},  // R4 branch at 3
    {2'd2, 3'd0, 6'b000000, 2'd0, 1'b0, 3'd4},  // R11
    {2'd0, 3'd7, 6'b000000, 2'd0, 1'b0, 3'd4},  // R4 branch at last slot
    {2'd2, 3'd0, 6'b000000, 2'd0, 1'b1, 3'd0},  // R11 R7
    {2'd0, 3'd6, 6'b000001, 2'd2, 1'b0, 3'd0}   // R5 R9 CR at 0 overlap
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset count", int'(slot_count_o), 0);
    check("R1 reset flag", int'(ctr_pending_o), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      issue_i      = (VEC[i][16:15] == 2'd1);
      advance_i    = (VEC[i][16:15] == 2'd2);
      unit_i       = VEC[i][14:12];
      first_only_i = VEC[i][11];
      single_i     = VEC[i][10];
      cracked_i    = VEC[i][9];
      sets_ctr_i   = VEC[i][8];
      uses_ctr_i   = VEC[i][7];
      overlap_i    = VEC[i][6];
      #1;
      check($sformatf("R10 verdict step %0d", i), int'(verdict_o), int'(VEC[i][5:4]));
      check($sformatf("R7 close step %0d", i), int'(group_close_o), int'(VEC[i][3]));
      @(posedge clk);
      #1;
      check($sformatf("R6 count step %0d", i), int'(slot_count_o), int'(VEC[i][2:0]));
      issue_i = 1'b0;
      advance_i = 1'b0;
    end

    // Directed: mid-group reset clears count and flag (R1)
    @(negedge clk);
    unit_i = 3'd1; first_only_i = 1'b0; single_i = 1'b0; cracked_i = 1'b0;
    sets_ctr_i = 1'b1; uses_ctr_i = 1'b0; overlap_i = 1'b0; issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0; sets_ctr_i = 1'b0;
    check("R8 flag raised", int'(ctr_pending_o), 1);
    check("R6 count after issue", int'(slot_count_o), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-group reset count", int'(slot_count_o), 0);
    check("R1 mid-group reset flag", int'(ctr_pending_o), 0);

    // Directed: single at slot 0 is legal (R2)
    unit_i = 3'd1; single_i = 1'b1;
    #1;
    check("R2 single at zero", int'(verdict_o), 0);
    single_i = 1'b0;

    finish_run();
  end

endmodule